// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external microprocessor exchange bytes with a local core through one 8-bit data bus. The host uses three active-low controls: chip select, read strobe and write strobe. Each control, and the incoming data bus, passes through a clock-domain synchroniser before anything decodes it. A small state machine then frames each host transfer. A host write stores the bus byte in an inbound register when the write ends. A host read drives the outbound register onto the pins for as long as the read lasts.

On the core side there is a plain register interface. The core loads the outbound byte, reads the inbound byte, and clears the interrupt and overflow flags. It can poll four flags: inbound-full, outbound-full, inbound-overflow and interrupt. Each host transfer raises the interrupt at the cycle where it ends. The two buffer-full flags show which side still has to act.

The state machine has three states:
- `ST_IDLE`: no transfer.
- `ST_HOST_WR`: a host write is in progress.
- `ST_HOST_RD`: a host read is in progress.

Its transitions are:
- IDLE→HOST_WR ("write start"): chip select and write strobe are both sampled low.
- IDLE→HOST_RD ("read start"): chip select and read strobe are both sampled low, and the write-start condition does not hold.
- HOST_WR→IDLE ("write end"): either chip select or write strobe is sampled high.
- HOST_RD→IDLE ("read end"): either chip select or read strobe is sampled high.
- any state→IDLE ("abort"): the mode enable goes low.

Top module: `par_slave_port`

## Requirements
- R1: After reset, inbound-full, outbound-full, overflow and interrupt are all 0, and the data pins are not driven (`pad_oe`=0).
- R2: While `mode_en` is 0, the host strobes are ignored. No transfer starts, `pad_oe` stays 0, and no flag changes.
- R3: When a host write ends, the synchronised bus byte is stored in `core_rdata`, and both `in_full` and `irq_flag` are set.
- R4: During a host read, `pad_oe` is 1 and `pad_out` carries the outbound byte. When the read ends, `pad_oe` returns to 0, `irq_flag` is set and `out_full` is cleared.
- R5: A core write made outside a host read loads the outbound byte, so `pad_out` shows it from the next cycle, and sets `out_full`.
- R6: A core write made during a host read shows on `pad_out` from the next cycle but leaves `out_full` unchanged.
- R7: A `core_rd_en` pulse clears `in_full`.
- R8: A host write that ends while `in_full` is 1 sets the sticky `in_ovf` flag and overwrites the inbound byte. Only `core_ovf_clr` clears `in_ovf`.
- R9: A `core_irq_clr` pulse clears `irq_flag`. If a transfer ends in the same cycle, the set takes priority.
- R10: A host write also ends when chip select rises before the write strobe does.
- R11: If read and write strobes are both low together with chip select at the start of a transfer, the transfer is treated as a write, and the pins are not driven.
- R12: Clearing `mode_en` during a transfer returns the machine to idle. The pins are released, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Slave port enable |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| pad_in | input | DATA_W | Data pins as seen from the host bus |
| pad_out | output | DATA_W | Value driven onto the data pins |
| pad_oe | output | 1 | Data pin output enable |
| core_wr_en | input | 1 | Core loads the outbound byte |
| core_wdata | input | DATA_W | Outbound byte from the core |
| core_rd_en | input | 1 | Core consumes the inbound byte |
| core_rdata | output | DATA_W | Inbound byte |
| core_irq_clr | input | 1 | Clears the interrupt flag |
| core_ovf_clr | input | 1 | Clears the overflow flag |
| in_full | output | 1 | Inbound byte not yet consumed |
| out_full | output | 1 | Outbound byte not yet read by host |
| in_ovf | output | 1 | Sticky inbound overflow |
| irq_flag | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the port with DATA_W=8 and SYNC_STAGES=3. The deeper chain stretches the latency from strobe to state change beyond the default, and every check is timed to allow for this. This makes transfers visible in which the strobe and chip-select edges are several cycles apart, including a write closed by chip select and a disable that lands in the middle of a read. Byte patterns with alternating and inverted bits test that every bit lane is captured on writes and driven on reads.

// File: rtl/psp_pkg.sv
package psp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOST_WR = 2'd1,
        ST_HOST_RD = 2'd2
    } psp_state_e;

endpackage

// File: rtl/psp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
module psp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/psp_fsm.sv
// Transfer framing: decides start and end of host reads and writes.
module psp_fsm
    import psp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cs_act,
    input  logic       rd_act,
    input  logic       wr_act,
    output psp_state_e state,
    output logic       wr_done,
    output logic       rd_done,
    output logic       drive
);
    psp_state_e nxt;
    logic       wr_sel;
    logic       rd_sel;

    assign wr_sel = cs_act && wr_act;
    assign rd_sel = cs_act && rd_act;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;                       // abort
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_sel)      nxt = ST_HOST_WR;   // write start
                    else if (rd_sel) nxt = ST_HOST_RD;   // read start
                end
                ST_HOST_WR: if (!wr_sel) nxt = ST_IDLE;  // write end
                ST_HOST_RD: if (!rd_sel) nxt = ST_IDLE;  // read end
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_done = 1'b0;
        rd_done = 1'b0;
        drive   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HOST_WR: wr_done = en && !wr_sel;
            ST_HOST_RD: begin
                drive   = 1'b1;
                rd_done = en && !rd_sel;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/psp_regs.sv
// Data registers and status flags.
module psp_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              core_wr_en,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_rd_en,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] out_byte,
    output logic              in_full,
    output logic              out_full,
    output logic              in_ovf,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_byte  <= '0;
            out_byte <= '0;
            in_full  <= 1'b0;
            out_full <= 1'b0;
            in_ovf   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (wr_done) in_byte <= bus_data;
            if (core_wr_en) out_byte <= core_wdata;

            if (wr_done)         in_full <= 1'b1;
            else if (core_rd_en) in_full <= 1'b0;

            if (rd_done)                        out_full <= 1'b0;
            else if (core_wr_en && !rd_active)  out_full <= 1'b1;

            if (wr_done && in_full) in_ovf <= 1'b1;
            else if (ovf_clr)       in_ovf <= 1'b0;

            if (wr_done || rd_done) irq <= 1'b1;
            else if (irq_clr)       irq <= 1'b0;
        end
    end
endmodule

// File: rtl/par_slave_port.sv
module par_slave_port
    import psp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    input  logic              core_wr_en,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_rd_en,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              core_irq_clr,
    input  logic              core_ovf_clr,
    output logic              in_full,
    output logic              out_full,
    output logic              in_ovf,
    output logic              irq_flag
);
    localparam int CTL_W = 3;

    logic [CTL_W-1:0]  ctl_s;
    logic [DATA_W-1:0] bus_s;
    psp_state_e        state;
    logic              wr_done;
    logic              rd_done;
    logic              drive;
    logic [DATA_W-1:0] out_byte;

    psp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({host_cs_n, host_rd_n, host_wr_n}),
        .q_sync  (ctl_s)
    );

    psp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL({DATA_W{1'b0}})) u_bus_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (bus_s)
    );

    psp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode_en),
        .cs_act  (!ctl_s[2]),
        .rd_act  (!ctl_s[1]),
        .wr_act  (!ctl_s[0]),
        .state   (state),
        .wr_done (wr_done),
        .rd_done (rd_done),
        .drive   (drive)
    );

    psp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .rd_active  (state == ST_HOST_RD),
        .bus_data   (bus_s),
        .core_wr_en (core_wr_en),
        .core_wdata (core_wdata),
        .core_rd_en (core_rd_en),
        .irq_clr    (core_irq_clr),
        .ovf_clr    (core_ovf_clr),
        .in_byte    (core_rdata),
        .out_byte   (out_byte),
        .in_full    (in_full),
        .out_full   (out_full),
        .in_ovf     (in_ovf),
        .irq        (irq_flag)
    );

    assign pad_out = out_byte;
    assign pad_oe  = drive;
endmodule

// File: rtl/psp_chk.sv
module psp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_en,
    input logic              core_wr_en,
    input logic [DATA_W-1:0] core_wdata,
    input logic [DATA_W-1:0] pad_out,
    input logic              pad_oe,
    input logic              in_full,
    input logic              out_full,
    input logic              in_ovf,
    input logic              irq_flag,
    input logic              wr_done,
    input logic              rd_done
);
    // R2
    dis_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !pad_oe);

    // R3
    wr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> irq_flag);

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !out_full);

    // R4
    one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, rd_done}));

    // R5
    core_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_en |=> (pad_out == $past(core_wdata)));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && pad_oe && !rd_done) |=> $stable(out_full));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ovf) |-> $past(in_full));
endmodule

bind par_slave_port psp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .core_wr_en (core_wr_en),
    .core_wdata (core_wdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .in_full    (in_full),
    .out_full   (out_full),
    .in_ovf     (in_ovf),
    .irq_flag   (irq_flag),
    .wr_done    (wr_done),
    .rd_done    (rd_done)
);

// File: tb/par_slave_port_test.sv
module par_slave_port_test;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int SS    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_en = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [DW-1:0] pad_in = '0;
    logic [DW-1:0] pad_out;
    logic          pad_oe;
    logic          core_wr_en = 1'b0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_rd_en = 1'b0;
    logic [DW-1:0] core_rdata;
    logic          irq_clr = 1'b0, ovf_clr = 1'b0;
    logic          in_full, out_full, in_ovf, irq_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #(CLK_P/2) clk = ~clk;

    par_slave_port #(.DATA_W(DW), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .core_wr_en(core_wr_en), .core_wdata(core_wdata),
        .core_rd_en(core_rd_en), .core_rdata(core_rdata),
        .core_irq_clr(irq_clr), .core_ovf_clr(ovf_clr),
        .in_full(in_full), .out_full(out_full), .in_ovf(in_ovf), .irq_flag(irq_flag)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: host write; queues the expected inbound byte when asked.
    task automatic host_write(logic [DW-1:0] d, bit end_by_cs, bit push);
        pad_in = d;
        tick(1);
        cs_n = 1'b0; wr_n = 1'b0;
        tick(6);
        if (end_by_cs) cs_n = 1'b1; else wr_n = 1'b1;
        tick(6);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(1);
        if (push) exp_q.push_back(d);
    endtask

    // Monitor: core read compares the inbound byte with the queue head.
    task automatic core_read(string req);
        logic [DW-1:0] e;
        if (exp_q.size() == 0) begin
            chk({req, " queue"}, 32'd0, 32'd1);
        end else begin
            e = exp_q.pop_front();
            chk(req, core_rdata, e);
        end
        core_rd_en = 1'b1;
        tick(1);
        core_rd_en = 1'b0;
    endtask

    task automatic core_write(logic [DW-1:0] d);
        core_wdata = d; core_wr_en = 1'b1;
        tick(1);
        core_wr_en = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 flags", {in_full, out_full, in_ovf, irq_flag}, 4'b0000);
        chk("R1 oe", pad_oe, 1'b0);

        // R2 disabled: strobes ignored
        host_write(8'h3C, 1'b0, 1'b0);
        chk("R2 write ignored", {in_full, irq_flag}, 2'b00);
        cs_n = 1'b0; rd_n = 1'b0; tick(6);
        chk("R2 read ignored", pad_oe, 1'b0);
        cs_n = 1'b1; rd_n = 1'b1; tick(6);
        chk("R2 irq", irq_flag, 1'b0);
        mode_en = 1'b1; tick(2);

        // R5 core write outside read
        core_write(8'hA5);
        chk("R5 pad_out", pad_out, 8'hA5);
        chk("R5 out_full", out_full, 1'b1);

        // R4 host read, R6 core write during read
        cs_n = 1'b0; rd_n = 1'b0; tick(6);
        chk("R4 oe", pad_oe, 1'b1);
        chk("R4 data", pad_out, 8'hA5);
        core_write(8'h5A);
        chk("R6 pad_out", pad_out, 8'h5A);
        chk("R6 out_full held 1", out_full, 1'b1);
        rd_n = 1'b1; tick(6);
        chk("R4 release", pad_oe, 1'b0);
        chk("R4 irq", irq_flag, 1'b1);
        chk("R4 out_full", out_full, 1'b0);
        cs_n = 1'b1; tick(1);

        // R9 clear irq
        clear_irq();
        chk("R9 irq clr", irq_flag, 1'b0);

        // R6 with out_full clear
        cs_n = 1'b0; rd_n = 1'b0; tick(6);
        core_write(8'h0F);
        chk("R6 out_full held 0", out_full, 1'b0);
        chk("R6 pad_out 0F", pad_out, 8'h0F);
        cs_n = 1'b1; rd_n = 1'b1; tick(6);
        clear_irq();

        // R3 host write, R7 core read
        host_write(8'hC3, 1'b0, 1'b1);
        chk("R3 in_full", in_full, 1'b1);
        chk("R3 irq", irq_flag, 1'b1);
        core_read("R3 data");
        chk("R7 in_full clr", in_full, 1'b0);
        clear_irq();

        // R10 write ended by chip select
        host_write(8'h96, 1'b1, 1'b1);
        chk("R10 in_full", in_full, 1'b1);
        core_read("R10 data");

        // R8 overflow
        host_write(8'h11, 1'b0, 1'b0);
        chk("R8 no ovf yet", in_ovf, 1'b0);
        host_write(8'h22, 1'b0, 1'b1);
        chk("R8 ovf set", in_ovf, 1'b1);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        chk("R8 ovf clr", in_ovf, 1'b0);
        chk("R8 in_full kept", in_full, 1'b1);
        core_read("R8 overwritten data");

        // R11 both strobes: write wins
        clear_irq();
        pad_in = 8'hE7; tick(1);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; tick(6);
        chk("R11 no drive", pad_oe, 1'b0);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; tick(6);
        exp_q.push_back(8'hE7);
        chk("R11 in_full", in_full, 1'b1);
        core_read("R11 data");

        // R12 disable mid read
        clear_irq();
        cs_n = 1'b0; rd_n = 1'b0; tick(6);
        chk("R12 oe before", pad_oe, 1'b1);
        mode_en = 1'b0; tick(2);
        chk("R12 oe released", pad_oe, 1'b0);
        cs_n = 1'b1; rd_n = 1'b1; tick(6);
        mode_en = 1'b1; tick(2);
        chk("R12 no irq", irq_flag, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule